// File: doc/BRIEF.md
# Compare-Match A/D Trigger Timer

This block produces start-of-conversion strobes for an analog-to-digital converter. It has two independent channels. Each channel has a 16-bit up-counter and two 16-bit compare registers, called A and B. A counter advances only on a clock where its channel's start input and its prescaler tick are both high. A prescaler outside the block supplies the tick as a clock enable.

Each compare register is checked against its channel's counter in every cycle. The counter may change by an increment or a bus write, or the compare register may be written. If equality holds after such a change, the block sends a one-clock trigger pulse and sets a sticky flag. Each flag has an interrupt enable. Software reaches the counters, compare registers, flags and enables through a simple word-wide register bus. Reads on that bus are combinational, and writes take effect on the next rising edge.

Top module: `adtrig_timer`

## Requirements
- R1: A counter increases by one on each rising edge where its `ch_run` bit and its `ch_tick` bit are both 1. Otherwise it keeps its value unless the bus writes it.
- R2: After reset every counter reads 16'h0001. A counter at 16'hFFFF that increments becomes 16'h0000 and keeps counting.
- R3: After reset all compare registers read 16'hFFFF, and all flags and all enables read 0.
- R4: Register map, read combinationally on `bus_rdata`:
  - Channel c (0 or 1) has its counter at address 4c, compare A at 4c+1 and compare B at 4c+2.
  - The flag word is at address 8 and the enable word at address 9.
  - Bit 2c+i of the flag and enable words belongs to channel c, compare i (A is i=0, B is i=1).
  - Any other address reads 0.
- R5: A write to a counter or compare register takes effect only when `bus_be` is 2'b11. Any other strobe pattern leaves the register unchanged.
- R6: A bus write to a counter in the same cycle as an increment loads the written value, and the increment is lost.
- R7: `conv_trig[2c+i]` is high for one clock in the cycle after an edge that changed counter c (by increment or write) or wrote compare i, when the counter then equals the compare value. It does not repeat while neither register changes.
- R8: A flag becomes 1 on the edge that ends the cycle in which its trigger pulse is high.
- R9: A write to the flag word clears each flag whose written bit is 0, but only if a flag-word read since the last flag-word write returned that flag as 1. Writing 1 has no effect. If a set and a clear meet on the same edge, the flag stays set.
- R10: `irq[k]` is high exactly when flag k and enable k are both 1.
- R11: Writes to the flag word and the enable word take effect when `bus_be[0]` is 1. Without it they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing) |
| bus_addr | input | 4 | Word address |
| bus_be | input | 2 | Byte strobes, bit 1 upper byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| ch_run | input | 2 | Per-channel counter start |
| ch_tick | input | 2 | Per-channel prescaler clock enable |
| conv_trig | output | 4 | Conversion start pulses, bit 2c+i |
| irq | output | 4 | Interrupt requests, bit 2c+i |

## Verification
The assertions assume that every input is known and changes only between rising edges once reset is released. The one-shot trigger property also assumes that an unchanged counter and compare register really mean no write and no increment reached them. The bench drives every input one nanosecond after a rising edge and holds it until the next edge, and it never leaves a bus field undriven. A long random phase uses small write values to hit compares, including clears that land on the same edge as a set, and compares every output with the model on every clock.

// File: rtl/adtrig_pkg.sv
package adtrig_pkg;
   // Word stride of one channel's register group: counter plus compares,
   // rounded up to a power of two so the group index is a plain bit field.
   function automatic int unsigned group_stride(int unsigned n_cmp);
      return 2 ** $clog2(n_cmp + 1);
   endfunction
endpackage

// File: rtl/adtrig_chan.sv
module adtrig_chan #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned N_CMP = 2,
   parameter logic [CNT_W-1:0] CNT_RST = 1,
   parameter logic [CNT_W-1:0] CMP_RST = '1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            run,
   input  logic                            tick,
   input  logic                            cnt_we,
   input  logic [N_CMP-1:0]                cmp_we,
   input  logic [CNT_W-1:0]                wdata,
   output logic [CNT_W-1:0]                cnt_q,
   output logic [N_CMP-1:0][CNT_W-1:0]     cmp_q,
   output logic [N_CMP-1:0]                trig
);
   logic             inc;
   logic             cnt_chg_q;
   logic [N_CMP-1:0] cmp_chg_q;

   assign inc = run & tick;

   // Counter: a bus write beats an increment.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= CNT_RST;
         cnt_chg_q <= 1'b0;
      end else begin
         if (cnt_we)
            cnt_q <= wdata;
         else if (inc)
            cnt_q <= cnt_q + 1'b1;
         cnt_chg_q <= cnt_we | inc;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_CMP; i++) cmp_q[i] <= CMP_RST;
         cmp_chg_q <= '0;
      end else begin
         for (int i = 0; i < N_CMP; i++)
            if (cmp_we[i]) cmp_q[i] <= wdata;
         cmp_chg_q <= cmp_we;
      end
   end

   // Equality only counts in the cycle after one of its operands moved.
   for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
      assign trig[i] = (cnt_chg_q | cmp_chg_q[i]) & (cnt_q == cmp_q[i]);

      assert_trig_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
         trig[i] && !inc && !cnt_we && !cmp_we[i] |=> !trig[i]);
   end

   assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !inc && !cnt_we |=> $stable(cnt_q));

   assert_wr_prio_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> cnt_q == $past(wdata));
endmodule

// File: rtl/adtrig_flags.sv
module adtrig_flags #(
   parameter int unsigned N_FLG = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_FLG-1:0] set,
   input  logic             st_rd,
   input  logic             st_we,
   input  logic             en_we,
   input  logic [N_FLG-1:0] wdata,
   output logic [N_FLG-1:0] flags,
   output logic [N_FLG-1:0] en,
   output logic [N_FLG-1:0] irq
);
   logic [N_FLG-1:0] armed;
   logic [N_FLG-1:0] clr;

   // Only flags seen as 1 by a read may be cleared by a later 0 write.
   assign clr = st_we ? (~wdata & armed) : '0;
   assign irq = flags & en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
         armed <= '0;
         en    <= '0;
      end else begin
         flags <= (flags & ~clr) | set;
         if (st_rd)
            armed <= flags;
         else if (st_we)
            armed <= '0;
         if (en_we)
            en <= wdata;
      end
   end

   for (genvar k = 0; k < N_FLG; k++) begin : g_chk
      assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
         set[k] |=> flags[k]);
      assert_flag_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(flags[k]) |-> $past(armed[k]) && $past(st_we));
      assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq[k]) |-> $past(set[k]) || $past(en_we));
   end
endmodule

// File: rtl/adtrig_timer.sv
module adtrig_timer
   import adtrig_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned N_CH  = 2,
   parameter int unsigned N_CMP = 2,
   parameter logic [CNT_W-1:0] CNT_RST = 1,
   parameter logic [CNT_W-1:0] CMP_RST = '1,
   localparam int unsigned N_FLG    = N_CH * N_CMP,
   localparam int unsigned STRIDE   = group_stride(N_CMP),
   localparam int unsigned STAT_ADR = N_CH * STRIDE,
   localparam int unsigned EN_ADR   = STAT_ADR + 1,
   localparam int unsigned ADDR_W   = $clog2(EN_ADR + 1),
   localparam int unsigned BE_W     = CNT_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BE_W-1:0]   bus_be,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic [N_CH-1:0]   ch_run,
   input  logic [N_CH-1:0]   ch_tick,
   output logic [N_FLG-1:0]  conv_trig,
   output logic [N_FLG-1:0]  irq
);
   if (N_FLG > CNT_W) begin : g_bad_flags
      $error("adtrig_timer: flag word cannot hold N_CH*N_CMP bits");
   end
   if (CNT_W % 8 != 0) begin : g_bad_width
      $error("adtrig_timer: CNT_W must be a whole number of bytes");
   end
   if (N_CH < 1 || N_CMP < 1) begin : g_bad_count
      $error("adtrig_timer: need at least one channel and one compare");
   end

   logic                        word_acc;
   logic [N_CH-1:0]             cnt_we;
   logic [N_CMP-1:0]            cmp_we [N_CH];
   logic [CNT_W-1:0]            cnt_q  [N_CH];
   logic [N_CMP-1:0][CNT_W-1:0] cmp_q  [N_CH];
   logic [N_FLG-1:0]            flags, en;
   logic                        st_rd, st_we, en_we;

   assign word_acc = &bus_be;
   assign st_rd = bus_rd & (bus_addr == ADDR_W'(STAT_ADR));
   assign st_we = bus_wr & bus_be[0] & (bus_addr == ADDR_W'(STAT_ADR));
   assign en_we = bus_wr & bus_be[0] & (bus_addr == ADDR_W'(EN_ADR));

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      assign cnt_we[c] = bus_wr & word_acc & (bus_addr == ADDR_W'(c * STRIDE));
      for (genvar i = 0; i < N_CMP; i++) begin : g_we
         assign cmp_we[c][i] = bus_wr & word_acc &
                               (bus_addr == ADDR_W'(c * STRIDE + 1 + i));
      end

      adtrig_chan #(
         .CNT_W(CNT_W), .N_CMP(N_CMP), .CNT_RST(CNT_RST), .CMP_RST(CMP_RST)
      ) chan_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (ch_run[c]),
         .tick   (ch_tick[c]),
         .cnt_we (cnt_we[c]),
         .cmp_we (cmp_we[c]),
         .wdata  (bus_wdata),
         .cnt_q  (cnt_q[c]),
         .cmp_q  (cmp_q[c]),
         .trig   (conv_trig[c*N_CMP +: N_CMP])
      );
   end

   adtrig_flags #(.N_FLG(N_FLG)) flags_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (conv_trig),
      .st_rd (st_rd),
      .st_we (st_we),
      .en_we (en_we),
      .wdata (bus_wdata[N_FLG-1:0]),
      .flags (flags),
      .en    (en),
      .irq   (irq)
   );

   always_comb begin
      bus_rdata = '0;
      for (int c = 0; c < N_CH; c++) begin
         if (bus_addr == ADDR_W'(c * STRIDE)) bus_rdata = cnt_q[c];
         for (int i = 0; i < N_CMP; i++)
            if (bus_addr == ADDR_W'(c * STRIDE + 1 + i)) bus_rdata = cmp_q[c][i];
      end
      if (bus_addr == ADDR_W'(STAT_ADR)) bus_rdata = CNT_W'(flags);
      if (bus_addr == ADDR_W'(EN_ADR))   bus_rdata = CNT_W'(en);
   end

   assert_byte_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && !word_acc && !ch_run[0] && bus_addr == ADDR_W'(0) |=> $stable(cnt_q[0]));
endmodule

// File: tb/adtrig_timer_tb_top.sv
module adtrig_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [1:0]  bus_be = 2'b11;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [1:0]  ch_run = '0, ch_tick = '0;
   logic [3:0]  conv_trig, irq;

   int nchk = 0, nfail = 0;
   bit done = 0;

   int       m_cnt [2];
   int       m_cmp [2][2];
   bit       m_cchg [2];
   bit       m_pchg [2][2];
   bit [3:0] m_flg, m_arm, m_en;

   always #2 clk = ~clk;

   adtrig_timer dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .ch_run(ch_run), .ch_tick(ch_tick),
      .conv_trig(conv_trig), .irq(irq)
   );

   task automatic chk(string tag, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit [3:0] exp_trig();
      bit [3:0] r = '0;
      for (int c = 0; c < 2; c++)
         for (int i = 0; i < 2; i++)
            r[2*c+i] = (m_cchg[c] || m_pchg[c][i]) && (m_cnt[c] == m_cmp[c][i]);
      return r;
   endfunction

   function automatic int exp_rd(int a);
      case (a)
         0: return m_cnt[0];
         1: return m_cmp[0][0];
         2: return m_cmp[0][1];
         4: return m_cnt[1];
         5: return m_cmp[1][0];
         6: return m_cmp[1][1];
         8: return int'(m_flg);
         9: return int'(m_en);
         default: return 0;
      endcase
   endfunction

   task automatic check_all();
      chk("R7 conv_trig", int'(conv_trig), int'(exp_trig()));
      chk("R10 irq", int'(irq), int'(m_flg & m_en));
      chk("R4 rdata", int'(bus_rdata), exp_rd(int'(bus_addr)));
   endtask

   task automatic model_reset();
      for (int c = 0; c < 2; c++) begin
         m_cnt[c] = 1; m_cchg[c] = 0;
         for (int i = 0; i < 2; i++) begin m_cmp[c][i] = 'hFFFF; m_pchg[c][i] = 0; end
      end
      m_flg = '0; m_arm = '0; m_en = '0;
   endtask

   task automatic model_update();
      bit [3:0] t = exp_trig();
      bit [3:0] clr;
      bit word = (bus_be == 2'b11);
      bit stw = bus_wr && bus_be[0] && bus_addr == 8;
      for (int c = 0; c < 2; c++) begin
         bit wc = bus_wr && word && bus_addr == 4*c;
         bit inc = ch_run[c] && ch_tick[c];
         if (wc) m_cnt[c] = int'(bus_wdata);
         else if (inc) m_cnt[c] = (m_cnt[c] + 1) & 'hFFFF;
         m_cchg[c] = wc || inc;
         for (int i = 0; i < 2; i++) begin
            bit wp = bus_wr && word && bus_addr == 4*c + 1 + i;
            if (wp) m_cmp[c][i] = int'(bus_wdata);
            m_pchg[c][i] = wp;
         end
      end
      clr = stw ? (~bus_wdata[3:0] & m_arm) : 4'b0;
      if (bus_rd && bus_addr == 8) m_arm = m_flg;
      else if (stw) m_arm = '0;
      m_flg = (m_flg & ~clr) | t;
      if (bus_wr && bus_be[0] && bus_addr == 9) m_en = bus_wdata[3:0];
   endtask

   task automatic step();
      #1;
      check_all();
      @(posedge clk);
      model_update();
      #1;
   endtask

   task automatic wr(int a, int d, bit [1:0] be = 2'b11);
      bus_wr = 1; bus_addr = 4'(a); bus_wdata = 16'(d); bus_be = be;
      step();
      bus_wr = 0; bus_be = 2'b11;
   endtask

   task automatic peek(int a, int exp, string tag);
      bus_rd = 1; bus_addr = 4'(a);
      #1;
      check_all();
      chk(tag, int'(bus_rdata), exp);
      @(posedge clk);
      model_update();
      #1;
      bus_rd = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R2, R3: reset values
      peek(0, 'h0001, "R2 counter0 reset");
      peek(4, 'h0001, "R2 counter1 reset");
      peek(1, 'hFFFF, "R3 cmpA0 reset");
      peek(6, 'hFFFF, "R3 cmpB1 reset");
      peek(8, 0, "R3 flags reset");
      peek(9, 0, "R3 enables reset");

      // R1, R7, R8, R10: channel 0 counts 1->5 and matches compare A
      wr(1, 5);
      wr(9, 'hF);
      ch_run[0] = 1; ch_tick[0] = 1;
      repeat (3) step();
      ch_tick[0] = 0;
      step();                       // no tick: counter holds at 4
      ch_tick[0] = 1;
      step();                       // counter becomes 5
      ch_run[0] = 0;
      #1 chk("R7 trig on match", int'(conv_trig[0]), 1);
      step();
      #1 chk("R7 no repeat while stopped", int'(conv_trig[0]), 0);
      chk("R10 irq after flag", int'(irq[0]), 1);
      peek(0, 5, "R1 counter value");
      peek(8, 1, "R8 flag set");

      // R9: clear without fresh read after a write is refused
      wr(8, 0);                     // was armed by read above: clears
      peek(8, 0, "R9 armed clear");
      wr(0, 4);  ch_run[0] = 1; ch_tick[0] = 1; step(); ch_run[0] = 0;
      step();
      wr(8, 0);                     // not read since last write: ignored
      peek(8, 1, "R9 clear without read ignored");
      wr(8, 'hF);                   // writing 1 does nothing; also disarms
      peek(8, 1, "R9 write one no effect");

      // R5, R11: partial strobes ignored
      wr(0, 'h1234, 2'b01);
      peek(0, 5, "R5 byte write ignored");
      wr(9, 0, 2'b10);
      peek(9, 'hF, "R11 enable needs low strobe");

      // R6: write beats increment
      ch_run[0] = 1;
      wr(0, 100);
      ch_run[0] = 0;
      peek(0, 100, "R6 write priority");

      // R2: wrap of channel 1 into a match on compare B at zero
      wr(4, 'hFFFE);
      wr(6, 0);
      ch_run[1] = 1; ch_tick[1] = 1;
      step(); step();
      ch_run[1] = 0;
      #1 chk("R7 trig after wrap", int'(conv_trig[3]), 1);
      peek(4, 0, "R2 wrap to zero");

      // Random phase: model compared on every clock
      for (int n = 0; n < 4000; n++) begin
         int op = $urandom_range(0, 9);
         ch_run  = 2'($urandom);
         ch_tick = 2'($urandom);
         bus_be  = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b11;
         bus_wr = 0; bus_rd = 0;
         bus_addr = 4'($urandom_range(0, 11));
         bus_wdata = 16'($urandom_range(0, 20));
         if (op < 3) bus_wr = 1;
         else if (op < 5) begin bus_rd = 1; bus_addr = 8; end
         else if (op == 5) begin bus_wr = 1; bus_addr = 8; bus_wdata = 16'($urandom); end
         step();
      end
      bus_wr = 0; bus_rd = 0; ch_run = 0; bus_be = 2'b11;
      step();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule